// File: doc/BRIEF.md
# Wavetable Tone Generator

The block turns a frequency step into a stream of signed 16-bit audio samples. A phase accumulator holds 9 integer bits and 16 fractional bits. It advances by the step each time the consumer takes a sample. The integer part of the phase indexes a 512-entry single-cycle waveform table. The table holds one period of a triangle wave, computed when the design elaborates. The table sits behind a registered address, so a read has one clock of latency.

Samples go to a downstream consumer, such as a serial codec transmitter, a FIFO or a pipeline register, through a valid/take handshake. The consumer decides when each sample is taken. At about 43.4 kHz, a tone of f Hz needs a step of f × 2^25 / 43403, rounded to the nearest integer. A step of zero silences the output and returns the phase to the start of the table.

Top module: `wavetable_tone`

## Requirements
- R1: While `rst_n` is low, and on the first falling clock edge after it is released, `sample_valid_o` is 0. One clock after release it is 1 and offers table entry 0 (0x8000), provided the step is nonzero.
- R2: Table entry a (0..511) holds m·256 − 32768 as 16-bit two's complement, where m = a for a < 256 and m = 511 − a otherwise.
- R3: With a constant nonzero step S, the k-th sample taken after reset (k from 0) is the table entry addressed by bits [24:16] of (k·S mod 2^25).
- R4: A take is a clock edge at which `take_i` and `sample_valid_o` are both 1. After a take, `sample_valid_o` is 0 for exactly one cycle and is then 1 again.
- R5: While `sample_valid_o` is 1, `take_i` is 0 and the step stays nonzero, `sample_o` holds its value.
- R6: A step of zero makes `sample_o` read 0x0000 from the next clock on and clears the phase. After a nonzero step is applied again, the first sample is table entry 0.
- R7: A change between nonzero steps keeps the phase. The next phase is the old phase plus the step present at the next take.
- R8: The phase wraps modulo 2^25, so the table index after entry 511 continues at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 25 | Phase step per sample, 9.16 fixed point; zero means silence |
| take_i | input | 1 | Consumer takes the offered sample |
| sample_valid_o | output | 1 | A sample is offered |
| sample_o | output | 16 | Signed sample |

## Verification
The assertions assume that `step_i` is steady across the edges they relate. They also assume that the consumer asserts `take_i` only as a level sampled at the clock. The hold property applies only when the step is nonzero on two successive edges. The stimulus drives `step_i` and `take_i` only at falling edges. It changes the step only while no take is pending, and it waits a full cycle after each change before it compares sample values.

// File: rtl/tone_pkg.sv
// Package: shared waveform arithmetic for the tone generator.
// Assumes idx_w >= 2 and samp_w >= idx_w; the result fits samp_w bits signed.
package tone_pkg;

    // Triangle wave value for table index idx: rises over the first half, falls over the second.
    function automatic logic [31:0] tri_value(int unsigned idx, int unsigned idx_w,
                                              int unsigned samp_w);
        int unsigned half;
        int unsigned m;
        int          v;
        half = 1 << (idx_w - 1);
        m    = (idx < half) ? idx : (2 * half - 1 - idx);
        v    = int'(m << (samp_w - idx_w + 1)) - int'(1 << (samp_w - 1));
        return v;
    endfunction

endpackage

// File: rtl/tone_phase.sv
// Phase accumulator: integer.fraction phase that advances by the step on each take.
// Assumes adv_i is a single-cycle pulse per accepted sample; a zero step clears the phase.
module tone_phase #(
    parameter int PH_W = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] step_i,
    input  logic            adv_i,
    output logic [PH_W-1:0] phase_o
);
    logic [PH_W-1:0] phase_q;

    // Accumulate the phase, clearing it on reset or when the step is zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (step_i == '0)
            phase_q <= '0;
        else if (adv_i)
            phase_q <= phase_q + step_i;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/tone_rom.sv
// Waveform table with a registered address: data follows the address with one clock of latency.
// Assumes the table fits the elaboration limits (DEPTH = 2**IDX_W); contents come from tone_pkg.
module tone_rom #(
    parameter int IDX_W  = 9,
    parameter int SAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  addr_i,
    input  logic              mute_i,
    output logic [SAMP_W-1:0] data_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [SAMP_W-1:0] table_w [DEPTH];
    logic [IDX_W-1:0]  addr_q;
    logic              mute_q;

    // Fill each table entry from the triangle formula.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        logic [31:0] full_w;
        assign full_w      = tone_pkg::tri_value(gi, IDX_W, SAMP_W);
        assign table_w[gi] = full_w[SAMP_W-1:0];
    end

    // Register the read address and the silence flag together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mute_q <= 1'b0;
        end else begin
            addr_q <= addr_i;
            mute_q <= mute_i;
        end
    end

    // Drive zeros while silenced, otherwise the addressed entry.
    always_comb begin
        data_o = mute_q ? '0 : table_w[addr_q];
    end
endmodule

// File: rtl/tone_handshake.sv
// Output handshake: offers a sample, drops valid for one cycle after each take while the table reloads.
// Assumes the consumer samples take_i at the clock edge.
module tone_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    output logic valid_o,
    output logic adv_o
);
    logic valid_q;

    // Valid rises one cycle after reset or after a take, once the new read completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else
            valid_q <= !(valid_q && take_i);
    end

    assign valid_o = valid_q;
    assign adv_o   = valid_q && take_i;
endmodule

// File: rtl/wavetable_tone.sv
// Top: frequency-stepped wavetable tone source with a valid/take output.
// Assumes step_i is a 9.16 fixed-point phase step and changes only between takes.
module wavetable_tone #(
    parameter int IDX_W  = 9,
    parameter int FRAC_W = 16,
    parameter int SAMP_W = 16,
    localparam int PH_W  = IDX_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   step_i,
    input  logic              take_i,
    output logic              sample_valid_o,
    output logic [SAMP_W-1:0] sample_o
);
    logic [PH_W-1:0] phase_w;
    logic            adv_w;
    logic            silent_w;

    assign silent_w = (step_i == '0);

    tone_handshake i_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take_i),
        .valid_o (sample_valid_o),
        .adv_o   (adv_w)
    );

    tone_phase #(.PH_W(PH_W)) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step_i),
        .adv_i   (adv_w),
        .phase_o (phase_w)
    );

    tone_rom #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) i_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (phase_w[PH_W-1 -: IDX_W]),
        .mute_i (silent_w),
        .data_o (sample_o)
    );
endmodule

// File: rtl/tone_checker.sv
// Checker: temporal properties of the tone generator's handshake and output, bound to the top.
// Assumes step_i and take_i are sampled at the clock edge like the design does.
module tone_checker #(
    parameter int PH_W   = 25,
    parameter int SAMP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PH_W-1:0]   step_i,
    input logic              take_i,
    input logic              sample_valid_o,
    input logic [SAMP_W-1:0] sample_o
);
    // A take is followed by one cycle without valid.
    p_gap_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_o && take_i) |=> !sample_valid_o);

    // A cycle without valid is always followed by valid.
    p_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid_o |=> sample_valid_o);

    // A zero step silences the output from the next cycle.
    p_silence_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0) |=> (sample_o == '0));

    // An offered sample that is not taken stays put while the step stays nonzero.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_o && !take_i && (step_i != '0) && $past(step_i != '0))
        |=> $stable(sample_o));
endmodule

bind wavetable_tone tone_checker #(.PH_W(PH_W), .SAMP_W(SAMP_W)) i_tone_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .step_i         (step_i),
    .take_i         (take_i),
    .sample_valid_o (sample_valid_o),
    .sample_o       (sample_o)
);

// File: tb/test_wavetable_tone.sv
// Bench: sweeps every table entry and several steps; expected samples computed arithmetically.
module test_wavetable_tone;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [24:0] step;
    logic        take;
    logic        valid;
    logic [15:0] sample;
    logic [24:0] model_ph;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    wavetable_tone i_wavetable_tone (
        .clk            (clk),
        .rst_n          (rst_n),
        .step_i         (step),
        .take_i         (take),
        .sample_valid_o (valid),
        .sample_o       (sample)
    );

    // Expected triangle entry for a phase value.
    function automatic logic [15:0] expect_at(logic [24:0] ph);
        int idx;
        int m;
        int v;
        idx = int'(ph[24:16]);
        m   = (idx < 256) ? idx : 511 - idx;
        v   = m * 256 - 32768;
        return v[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // At a falling edge with valid expected high: check the offer, take it, check the gap.
    task automatic take_one(input string req);
        logic [15:0] e;
        e = (step == '0) ? 16'h0000 : expect_at(model_ph);
        chk(valid == 1'b1, "R4", int'(valid), 1);
        chk(sample == e, req, int'(sample), int'(e));
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        model_ph = (step == '0) ? '0 : model_ph + step;
        chk(valid == 1'b0, "R4", int'(valid), 0);
        @(negedge clk);
    endtask

    task automatic set_step(input logic [24:0] s);
        step = s;
        if (s == '0) model_ph = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        step  = 25'h1_0000;
        take  = 1'b0;
        model_ph = '0;
        repeat (3) @(negedge clk);
        chk(valid == 1'b0, "R1", int'(valid), 0);
        rst_n = 1'b1;
        chk(valid == 1'b0, "R1", int'(valid), 0);
        @(negedge clk);
        chk(valid == 1'b1, "R1", int'(valid), 1);
        chk(sample == 16'h8000, "R1", int'(sample), 16'h8000);

        // R2: one entry per sample visits every table index; R8: then wraps.
        for (int k = 0; k < 520; k++) take_one(k < 512 ? "R2" : "R8");

        // R5: no take, offer must hold.
        for (int k = 0; k < 6; k++) begin
            chk(valid == 1'b1, "R5", int'(valid), 1);
            chk(sample == expect_at(model_ph), "R5", int'(sample), int'(expect_at(model_ph)));
            @(negedge clk);
        end

        // R3 and R7: several steps, phase carried across each change.
        for (int s = 0; s < 5; s++) begin
            logic [24:0] st;
            case (s)
                0:       st = 25'h000_0001;
                1:       st = 25'h000_3039;
                2:       st = 25'h003_0309;
                3:       st = 25'h1FF_FFFF;
                default: st = 25'h0AB_CDEF;
            endcase
            set_step(st);
            take_one("R7");
            for (int k = 0; k < 150; k++) take_one("R3");
        end

        // R6: silence, phase cleared, restart from entry 0.
        set_step('0);
        for (int k = 0; k < 4; k++) take_one("R6");
        set_step(25'h002_4000);
        chk(sample == 16'h8000, "R6", int'(sample), 16'h8000);
        for (int k = 0; k < 40; k++) take_one("R3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule